// File: doc/BRIEF.md
# Shared Steering Lock Semaphore

This block is a one-bit hardware lock that several agents reach through a single semaphore register. Host software, a firmware engine and other hardware masters all use it to serialise access to a shared steering selector. Each agent has its own register access port, and the index of that port is the agent's identity. An agent tries to take the lock by reading the register. A read that returns one means the lock is now held by that agent. A read that returns zero means the agent must poll again. The holder frees the lock by writing one.

Each access port is a single-beat register port. A request is presented for exactly one cycle with a valid strobe. Each read is answered one cycle later with a response strobe and data. The lock accepts a request in every cycle, so there is no back-pressure and no ready signal. A separate maintenance write port forces the lock free at start-up or resume, whichever agent still holds it. A busy output and an owner index let the rest of the chip see the lock state. Timeouts are the agents' own concern.

Top module: `steer_sem_top`

## Requirements
- R1: After reset the lock is free: `busy` is 0, `owner_id` is 0 and no `rsp_valid` bit is set.
- R2: A read by agent i while the lock is free and no maintenance release is present returns data value 1 in the next cycle. From that cycle on, `busy` is 1 and `owner_id` equals i.
- R3: A read while the lock is held returns data value 0 and leaves `busy` and `owner_id` unchanged. `owner_id` changes only when a free lock is granted.
- R4: When several agents read a free lock in the same cycle, the lowest-numbered agent wins and is the only one to see value 1. The other readers see 0.
- R5: A write of value 1 from the current holder frees the lock. `busy` is 0 in the next cycle.
- R6: A write from an agent that does not hold the lock is ignored. A write of any value other than 1, even from the holder, is also ignored.
- R7: A maintenance write of value 1 frees the lock in the next cycle, whoever holds it. Reads presented in that same cycle all return 0. A maintenance write of any other value is ignored.
- R8: Every read (valid with write low) gets exactly one `rsp_valid` pulse in the following cycle. Writes get no response.
- R9: When the holder releases and another agent reads in the same cycle, the read sees the lock as held and returns 0. The lock is free afterwards.
- R10: While the lock is free, `owner_id` reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | N_AGENTS | Per-agent request strobe, one cycle per access |
| req_write | input | N_AGENTS | Per-agent access kind: 1 for write, 0 for read |
| req_wdata | input | N_AGENTS*DATA_W | Per-agent write data; agent i uses slice i |
| rsp_valid | output | N_AGENTS | Per-agent read response strobe, one cycle after the read |
| rsp_data | output | N_AGENTS*DATA_W | Per-agent read data: 1 means granted, 0 means retry |
| maint_valid | input | 1 | Maintenance write strobe |
| maint_wdata | input | DATA_W | Maintenance write data; value 1 forces the lock free |
| busy | output | 1 | Lock is held |
| owner_id | output | ID_W | Index of the holding agent; 0 while free |

## Verification
The assertions assume that each request strobe lasts one cycle. They also assume that `req_write` and the write data are meaningful only while the strobe is high, and that reset is applied before the first access. The bench drives every input at the falling edge and holds it for exactly one cycle. Random traffic mixes reads, release writes of value 1 and other values, and rare maintenance writes. This covers simultaneous reads, releases that collide with reads, and writes from non-holders.

// File: rtl/steer_sem_pkg.sv
package steer_sem_pkg;
  // Value that grants on read and releases on write.
  localparam int unsigned SEM_TOKEN = 1;

  typedef struct packed {
    logic rd;
    logic rel;
  } acc_kind_t;
endpackage

// File: rtl/steer_sem_decode.sv
module steer_sem_decode
  import steer_sem_pkg::*;
#(
  parameter int unsigned N_AGENTS = 4,
  parameter int unsigned DATA_W   = 32
) (
  input  logic [N_AGENTS-1:0]        req_valid,
  input  logic [N_AGENTS-1:0]        req_write,
  input  logic [N_AGENTS*DATA_W-1:0] req_wdata,
  output logic [N_AGENTS-1:0]        rd_vec,
  output logic [N_AGENTS-1:0]        rel_vec
);
  localparam logic [DATA_W-1:0] TOKEN = DATA_W'(SEM_TOKEN);

  for (genvar g = 0; g < N_AGENTS; g++) begin : g_dec
    acc_kind_t kind;
    always_comb begin
      kind.rd  = req_valid[g] && !req_write[g];
      kind.rel = req_valid[g] && req_write[g] &&
                 (req_wdata[g*DATA_W +: DATA_W] == TOKEN);
    end
    assign rd_vec[g]  = kind.rd;
    assign rel_vec[g] = kind.rel;
  end
endmodule

// File: rtl/steer_sem_prio_arb.sv
module steer_sem_prio_arb #(
  parameter int unsigned N_AGENTS = 4,
  localparam int unsigned ID_W    = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
  input  logic [N_AGENTS-1:0] req,
  output logic [N_AGENTS-1:0] gnt,
  output logic                any,
  output logic [ID_W-1:0]     gnt_id
);
  logic [N_AGENTS:0] blocked;
  assign blocked[0] = 1'b0;

  for (genvar g = 0; g < N_AGENTS; g++) begin : g_chain
    assign gnt[g]       = req[g] && !blocked[g];
    assign blocked[g+1] = blocked[g] || req[g];
  end

  assign any = blocked[N_AGENTS];

  always_comb begin
    gnt_id = '0;
    for (int i = N_AGENTS - 1; i >= 0; i--) begin
      if (req[i]) gnt_id = ID_W'(i);
    end
  end
endmodule

// File: rtl/steer_sem_lock_core.sv
module steer_sem_lock_core #(
  parameter int unsigned N_AGENTS = 4,
  localparam int unsigned ID_W    = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                take,
  input  logic [ID_W-1:0]     take_id,
  input  logic [N_AGENTS-1:0] rel_vec,
  input  logic                force_free,
  output logic                held,
  output logic [ID_W-1:0]     owner
);
  logic            held_q;
  logic [ID_W-1:0] owner_q;
  logic            owner_rel;

  assign owner_rel = held_q && rel_vec[owner_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q  <= 1'b0;
      owner_q <= '0;
    end else if (force_free || owner_rel) begin
      held_q  <= 1'b0;
    end else if (!held_q && take) begin
      held_q  <= 1'b1;
      owner_q <= take_id;
    end
  end

  assign held  = held_q;
  assign owner = held_q ? owner_q : '0;
endmodule

// File: rtl/steer_sem_top.sv
module steer_sem_top
  import steer_sem_pkg::*;
#(
  parameter int unsigned N_AGENTS = 4,
  parameter int unsigned DATA_W   = 32,
  localparam int unsigned ID_W    = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_AGENTS-1:0]         req_valid,
  input  logic [N_AGENTS-1:0]         req_write,
  input  logic [N_AGENTS*DATA_W-1:0]  req_wdata,
  output logic [N_AGENTS-1:0]         rsp_valid,
  output logic [N_AGENTS*DATA_W-1:0]  rsp_data,
  input  logic                        maint_valid,
  input  logic [DATA_W-1:0]           maint_wdata,
  output logic                        busy,
  output logic [ID_W-1:0]             owner_id
);
  localparam logic [DATA_W-1:0] TOKEN = DATA_W'(SEM_TOKEN);

  logic [N_AGENTS-1:0] rd_vec, rel_vec, arb_req, gnt;
  logic                gnt_any, held, force_free;
  logic [ID_W-1:0]     gnt_id;

  steer_sem_decode #(.N_AGENTS(N_AGENTS), .DATA_W(DATA_W)) u_dec (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_wdata (req_wdata),
    .rd_vec    (rd_vec),
    .rel_vec   (rel_vec)
  );

  assign force_free = maint_valid && (maint_wdata == TOKEN);
  assign arb_req    = (held || force_free) ? '0 : rd_vec;

  steer_sem_prio_arb #(.N_AGENTS(N_AGENTS)) u_arb (
    .req    (arb_req),
    .gnt    (gnt),
    .any    (gnt_any),
    .gnt_id (gnt_id)
  );

  steer_sem_lock_core #(.N_AGENTS(N_AGENTS)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (gnt_any),
    .take_id    (gnt_id),
    .rel_vec    (rel_vec),
    .force_free (force_free),
    .held       (held),
    .owner      (owner_id)
  );

  assign busy = held;

  for (genvar g = 0; g < N_AGENTS; g++) begin : g_rsp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rsp_valid[g]                  <= 1'b0;
        rsp_data[g*DATA_W +: DATA_W]  <= '0;
      end else begin
        rsp_valid[g]                  <= rd_vec[g];
        rsp_data[g*DATA_W +: DATA_W]  <= gnt[g] ? TOKEN : '0;
      end
    end
  end
endmodule

// File: rtl/steer_sem_checker.sv
module steer_sem_checker #(
  parameter int unsigned N_AGENTS = 4,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ID_W     = 2
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [N_AGENTS-1:0]         req_valid,
  input logic [N_AGENTS-1:0]         req_write,
  input logic [N_AGENTS*DATA_W-1:0]  rsp_data,
  input logic [N_AGENTS-1:0]         rsp_valid,
  input logic                        maint_valid,
  input logic [DATA_W-1:0]           maint_wdata,
  input logic                        busy,
  input logic [ID_W-1:0]             owner_id
);
  logic [N_AGENTS-1:0] won;
  for (genvar g = 0; g < N_AGENTS; g++) begin : g_won
    assign won[g] = rsp_valid[g] && (rsp_data[g*DATA_W +: DATA_W] == DATA_W'(1));

    assert_grant_takes_R2: assert property (@(posedge clk) disable iff (!rst_n)
      won[g] |-> (busy && owner_id == ID_W'(g) && !$past(busy)));

    assert_rsp_follows_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid[g] |-> $past(req_valid[g] && !req_write[g]));
  end

  assert_single_winner_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(won));

  assert_owner_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(owner_id));

  assert_maint_frees_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (maint_valid && maint_wdata == DATA_W'(1)) |=> (!busy && won == '0));

  assert_free_owner_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> owner_id == '0);
endmodule

bind steer_sem_top steer_sem_checker #(
  .N_AGENTS (N_AGENTS),
  .DATA_W   (DATA_W),
  .ID_W     (ID_W)
) u_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_write   (req_write),
  .rsp_data    (rsp_data),
  .rsp_valid   (rsp_valid),
  .maint_valid (maint_valid),
  .maint_wdata (maint_wdata),
  .busy        (busy),
  .owner_id    (owner_id)
);

// File: tb/steer_sem_top_tb_top.sv
module steer_sem_top_tb_top;
  localparam int N  = 4;
  localparam int DW = 32;
  localparam int IW = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [N-1:0]      req_valid = '0, req_write = '0;
  logic [N*DW-1:0]   req_wdata = '0;
  logic [N-1:0]      rsp_valid;
  logic [N*DW-1:0]   rsp_data;
  logic              maint_valid = 1'b0;
  logic [DW-1:0]     maint_wdata = '0;
  logic              busy;
  logic [IW-1:0]     owner_id;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  m_busy = 1'b0;
  int  m_owner = 0;
  bit  finished = 1'b0;

  always #10 clk = ~clk;

  steer_sem_top #(.N_AGENTS(N), .DATA_W(DW)) dut_i (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_write (req_write), .req_wdata (req_wdata),
    .rsp_valid (rsp_valid), .rsp_data (rsp_data),
    .maint_valid (maint_valid), .maint_wdata (maint_wdata),
    .busy (busy), .owner_id (owner_id)
  );

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Expected winner of a read round, -1 when none.
  function automatic int model_winner(input logic [N-1:0] rd, input bit clr);
    if (m_busy || clr) return -1;
    for (int i = 0; i < N; i++) if (rd[i]) return i;
    return -1;
  endfunction

  task automatic step(input logic [N-1:0] rv, input logic [N-1:0] rw,
                      input logic [N*DW-1:0] wd, input bit mv,
                      input logic [DW-1:0] md, input string tag);
    logic [N-1:0] rd;
    bit clr;
    int win;
    @(negedge clk);
    req_valid = rv; req_write = rw; req_wdata = wd;
    maint_valid = mv; maint_wdata = md;
    rd  = rv & ~rw;
    clr = mv && (md == 1);
    win = model_winner(rd, clr);
    @(posedge clk);
    #2;
    check(tag, "rsp_valid", rsp_valid, rd);
    for (int i = 0; i < N; i++)
      if (rd[i]) check(tag, $sformatf("rsp_data[%0d]", i),
                       rsp_data[i*DW +: DW], (i == win) ? 1 : 0);
    if (clr) m_busy = 1'b0;
    else if (m_busy && rv[m_owner] && rw[m_owner] && wd[m_owner*DW +: DW] == 1) m_busy = 1'b0;
    else if (win >= 0) begin m_busy = 1'b1; m_owner = win; end
    check(tag, "busy", busy, m_busy);
    check(tag, "owner_id", owner_id, m_busy ? m_owner : 0);
    @(negedge clk);
    req_valid = '0; maint_valid = 1'b0;
  endtask

  function automatic logic [N*DW-1:0] wslot(input int a, input logic [DW-1:0] v);
    logic [N*DW-1:0] r = '0;
    r[a*DW +: DW] = v;
    return r;
  endfunction

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #2;
    check("R1", "busy", busy, 0);
    check("R1", "owner_id", owner_id, 0);
    check("R1", "rsp_valid", rsp_valid, 0);
    @(negedge clk); rst_n = 1'b1;

    step(4'b0100, 4'b0000, '0, 0, 0, "R2");               // agent 2 takes
    step(4'b0010, 4'b0000, '0, 0, 0, "R3");               // agent 1 polls, held
    step(4'b0010, 4'b0010, wslot(1, 1), 0, 0, "R6");      // non-holder release
    step(4'b0100, 4'b0100, wslot(2, 5), 0, 0, "R6");      // wrong value
    step(4'b0100, 4'b0100, wslot(2, 1), 0, 0, "R5");      // holder release
    step(4'b1010, 4'b0000, '0, 0, 0, "R4");               // 1 beats 3
    step(4'b0011, 4'b0010, wslot(1, 1), 0, 0, "R9");      // release + read
    step(4'b0001, 4'b0000, '0, 0, 0, "R10");              // free again: grant 0
    step(4'b0000, 4'b0000, '0, 1, 7, "R7");               // bad maint value
    step(4'b0000, 4'b0000, '0, 1, 1, "R7");               // maint frees
    step(4'b1000, 4'b0000, '0, 1, 1, "R7");               // maint beats read
    step(4'b0001, 4'b0001, wslot(0, 1), 0, 0, "R8");      // write, no response

    for (int c = 0; c < 2000; c++) begin
      logic [N-1:0] rv, rw;
      logic [N*DW-1:0] wd;
      rv = N'($urandom);
      rw = N'($urandom);
      for (int i = 0; i < N; i++)
        wd[i*DW +: DW] = ($urandom % 4 != 0) ? DW'(1) : DW'($urandom % 6);
      step(rv, rw, wd, ($urandom % 40) == 0, DW'($urandom % 2),
           "R2/R3/R4/R5/R6/R7/R8/R9");
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule